// File: doc/BRIEF.md
# Commutation-Step PWM Side Steering

This block holds the control byte for one sensorless brushless-motor commutation stage and turns it into per-phase gate enables. A commutation step is divided into three intervals: from the commutation event (C) to the demagnetization event (D), from D to the zero-crossing event (Z), and from Z to the next C. For each interval, one mode bit selects whether the PWM carrier chops the high-side channels or the low-side channels. The other side stays on continuously. The phase pattern comes from outside on two selection vectors, one for high-side phases and one for low-side phases. The block only decides which selected switch is chopped and which is held on.

Four fields are double-buffered: the zero-crossing edge, the two demagnetization enables and the C-to-D side bit. Software writes them at any time, and they become active only on a C event. A C event is either the C strobe or a phase-state write while direct-access mode is on. The over-current bit and the other two side bits act as soon as they are written.

Current-limit handling follows a three-input rule. The current-loop indication cuts the PWM carrier. When the current-limit flag is also set, an interrupt is raised. When the over-current bit is set as well, the master output enable drops and every gate goes low. The enable stays low until software sets it again.

Top module: `pwm_step_steer`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x00, `moe` is 0, `step_iv` is 0 and all gates are 0.
- R2: Bit 7 of the control byte always reads back 0, whatever value is written to it.
- R3: Bit 6 (zero-crossing edge, 1 = rising) drives `zc_rising`. Bit 5 drives `hdm_en` and bit 4 drives `sdm_en` (1 = enabled). These outputs change only in the cycle after a C event. A C event is `ev_c`, or `phase_wr` while `direct_mode` is 1. A write made in the same cycle as a C event is applied by that event. `ctrl_rd` shows the written value in the cycle after the write.
- R4: Bit 2 (side for the C-to-D interval) is preloaded in the same way as R3. Bit 3 (over-current enable), bit 1 (side for D-to-Z) and bit 0 (side for Z-to-C) act in the cycle after the write.
- R5: `step_iv` encodes the interval as 0 = C-to-D, 1 = D-to-Z, 2 = Z-to-C. A C event sets it to 0 and has priority over the other strobes. `ev_d` moves it from 0 to 1 and `ev_z` moves it from 1 to 2. Any other strobe leaves it unchanged.
- R6: The side bit of the current interval selects the chopped side. With side 0, `hi_gate[p]` follows the carrier for each phase p with `hi_sel[p]` set, and `lo_gate[p]` is 1 for each phase p with `lo_sel[p]` set. With side 1 the two roles swap. A gate whose select bit is 0 is 0.
- R7: While `cli` is 1, the chopped side sees the carrier as 0. The continuously-on side is not affected.
- R8: `oc_irq` is 1 in exactly those cycles where `clim` and `cli` are both 1.
- R9: If `clim`, `cli` and the active over-current bit are all 1 at a clock edge, `moe` is 0 after that edge, and this takes priority over `moe_set`. Otherwise `moe_set` makes `moe` 1 after the edge. Without either condition, `moe` keeps its value.
- R10: While `moe` is 0, every `hi_gate` and `lo_gate` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| ctrl_rd | output | 8 | Control byte readback (written values) |
| ev_c | input | 1 | Commutation event strobe |
| ev_d | input | 1 | Demagnetization event strobe |
| ev_z | input | 1 | Zero-crossing event strobe |
| direct_mode | input | 1 | Direct-access mode; phase writes act as C events |
| phase_wr | input | 1 | Phase-state register write strobe |
| pwm_in | input | 1 | PWM carrier |
| hi_sel | input | NPH | High-side phases active in this step |
| lo_sel | input | NPH | Low-side phases active in this step |
| clim | input | 1 | Current-limit flag |
| cli | input | 1 | Current-loop indication |
| moe_set | input | 1 | Software set of the master output enable |
| hi_gate | output | NPH | High-side gate enables |
| lo_gate | output | NPH | Low-side gate enables |
| moe | output | 1 | Master output enable |
| oc_irq | output | 1 | Over-current interrupt request |
| zc_rising | output | 1 | Active zero-crossing edge select |
| hdm_en | output | 1 | Active hardware demagnetization enable |
| sdm_en | output | 1 | Active simulated demagnetization enable |
| step_iv | output | 2 | Current step interval |

## Verification
The bench builds the block with the default of three phases. With three phases, independent random high and low selections produce phases that are high-only, low-only, both and neither, all within the same step. Random strobes reach every interval in order and also deliver out-of-order D and Z strobes. Sparse writes land both before and on the cycle of a C event, including C events produced through the direct-mode phase write. Over-current trips occur with and without a simultaneous `moe_set`, so the priority rule and the sticky enable are both exercised.

// File: rtl/pwm_step_steer.sv
module pwm_step_steer #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  output logic [7:0]     ctrl_rd,
  input  logic           ev_c,
  input  logic           ev_d,
  input  logic           ev_z,
  input  logic           direct_mode,
  input  logic           phase_wr,
  input  logic           pwm_in,
  input  logic [NPH-1:0] hi_sel,
  input  logic [NPH-1:0] lo_sel,
  input  logic           clim,
  input  logic           cli,
  input  logic           moe_set,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate,
  output logic           moe,
  output logic           oc_irq,
  output logic           zc_rising,
  output logic           hdm_en,
  output logic           sdm_en,
  output logic [1:0]     step_iv
);
  localparam logic [1:0] IV_CD = 2'd0;
  localparam logic [1:0] IV_DZ = 2'd1;
  localparam logic [1:0] IV_ZC = 2'd2;

  logic [7:0] shadow, shadow_nx;
  logic [3:0] act;
  logic [1:0] iv;
  logic       moe_q, c_evt, trip, side, chop;

  assign c_evt     = ev_c | (direct_mode & phase_wr);
  assign shadow_nx = wr_en ? (wr_data & 8'h7F) : shadow;
  assign trip      = clim & cli & shadow[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      shadow <= shadow_nx;
      if (c_evt) act <= {shadow_nx[6:4], shadow_nx[2]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      iv <= IV_CD;
    else if (c_evt)                  iv <= IV_CD;
    else if (ev_d && iv == IV_CD)    iv <= IV_DZ;
    else if (ev_z && iv == IV_DZ)    iv <= IV_ZC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       moe_q <= 1'b0;
    else if (trip)    moe_q <= 1'b0;
    else if (moe_set) moe_q <= 1'b1;
  end

  always_comb begin
    case (iv)
      IV_CD:   side = act[0];
      IV_DZ:   side = shadow[1];
      default: side = shadow[0];
    endcase
  end

  assign chop = pwm_in & ~cli;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign hi_gate[p] = moe_q & hi_sel[p] & (side ? 1'b1 : chop);
    assign lo_gate[p] = moe_q & lo_sel[p] & (side ? chop : 1'b1);
  end

  assign ctrl_rd   = shadow;
  assign moe       = moe_q;
  assign oc_irq    = clim & cli;
  assign zc_rising = act[3];
  assign hdm_en    = act[2];
  assign sdm_en    = act[1];
  assign step_iv   = iv;
endmodule

// File: rtl/pwm_step_steer_chk.sv
module pwm_step_steer_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ev_c,
  input logic           ev_d,
  input logic           ev_z,
  input logic           direct_mode,
  input logic           phase_wr,
  input logic           clim,
  input logic           cli,
  input logic           moe_set,
  input logic [7:0]     ctrl_rd,
  input logic [NPH-1:0] hi_sel,
  input logic [NPH-1:0] lo_sel,
  input logic [NPH-1:0] hi_gate,
  input logic [NPH-1:0] lo_gate,
  input logic           moe,
  input logic           oc_irq,
  input logic           zc_rising,
  input logic           hdm_en,
  input logic           sdm_en,
  input logic [1:0]     step_iv
);
  logic cev;
  assign cev = ev_c | (direct_mode & phase_wr);

  assert_preload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cev |=> ($stable(zc_rising) && $stable(hdm_en) && $stable(sdm_en)));

  assert_iv_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_iv != 2'd3);

  assert_c_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cev |=> step_iv == 2'd0);

  assert_d_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cev && ev_d && step_iv == 2'd0) |=> step_iv == 2'd1);

  assert_z_from_cd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cev && !ev_d && ev_z && step_iv == 2'd0) |=> step_iv == 2'd0);

  assert_unselected_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_gate & ~hi_sel) == '0) && ((lo_gate & ~lo_sel) == '0));

  assert_irq_needs_cli_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oc_irq |-> (clim && cli));

  assert_trip_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clim && cli && ctrl_rd[3]) |=> !moe);

  assert_moe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe && !moe_set) |=> !moe);

  assert_gates_dead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !moe |-> (hi_gate == '0 && lo_gate == '0));
endmodule

bind pwm_step_steer pwm_step_steer_chk #(.NPH(NPH)) u_chk (.*);

// File: tb/pwm_step_steer_tb.sv
module pwm_step_steer_tb;
  localparam int NPH = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ev_c = 0, ev_d = 0, ev_z = 0, direct_mode = 0, phase_wr = 0;
  logic pwm_in = 0, clim = 0, cli = 0, moe_set = 0;
  logic [7:0] wr_data = 0;
  logic [NPH-1:0] hi_sel = 0, lo_sel = 0;
  logic [7:0] ctrl_rd;
  logic [NPH-1:0] hi_gate, lo_gate;
  logic moe, oc_irq, zc_rising, hdm_en, sdm_en;
  logic [1:0] step_iv;

  pwm_step_steer #(.NPH(NPH)) u_dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  int m_sh, m_act_zc, m_act_hdm, m_act_sdm, m_act_os2, m_iv, m_moe;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_sh = 0; m_act_zc = 0; m_act_hdm = 0; m_act_sdm = 0; m_act_os2 = 0; m_iv = 0; m_moe = 0;
  endtask

  task automatic model_edge();
    int nsh, c, trip;
    c = ev_c || (direct_mode && phase_wr);
    nsh = wr_en ? (int'(wr_data) % 128) : m_sh;
    trip = clim && cli && ((m_sh / 8) % 2);
    if (c) begin
      m_act_zc = (nsh / 64) % 2; m_act_hdm = (nsh / 32) % 2;
      m_act_sdm = (nsh / 16) % 2; m_act_os2 = (nsh / 4) % 2;
    end
    if (c) m_iv = 0;
    else if (ev_d && m_iv == 0) m_iv = 1;
    else if (ev_z && m_iv == 1) m_iv = 2;
    if (trip) m_moe = 0;
    else if (moe_set) m_moe = 1;
    m_sh = nsh;
  endtask

  task automatic compare_all();
    int side, carrier, eh, el;
    side = (m_iv == 0) ? m_act_os2 : (m_iv == 1) ? (m_sh / 2) % 2 : m_sh % 2;
    carrier = pwm_in && !cli;
    chk("R2", "ctrl_rd[7]", int'(ctrl_rd[7]), 0);
    chk("R4", "ctrl_rd", int'(ctrl_rd), m_sh);
    chk("R3", "zc_rising", int'(zc_rising), m_act_zc);
    chk("R3", "hdm_en", int'(hdm_en), m_act_hdm);
    chk("R3", "sdm_en", int'(sdm_en), m_act_sdm);
    chk("R5", "step_iv", int'(step_iv), m_iv);
    chk("R8", "oc_irq", int'(oc_irq), int'(clim && cli));
    chk("R9", "moe", int'(moe), m_moe);
    for (int p = 0; p < NPH; p++) begin
      eh = m_moe && hi_sel[p] && (side ? 1 : carrier);
      el = m_moe && lo_sel[p] && (side ? carrier : 1);
      chk(m_moe ? (cli ? "R7" : "R6") : "R10", "hi_gate", int'(hi_gate[p]), eh);
      chk(m_moe ? (cli ? "R7" : "R6") : "R10", "lo_gate", int'(lo_gate[p]), el);
    end
  endtask

  task automatic drive_random(int phase);
    wr_en = ($urandom % 8) == 0;
    wr_data = 8'($urandom);
    ev_c = ($urandom % 10) == 0;
    ev_d = ($urandom % 4) == 0;
    ev_z = ($urandom % 4) == 0;
    direct_mode = ($urandom % 2) == 0;
    phase_wr = ($urandom % 12) == 0;
    pwm_in = ($urandom % 2) == 0;
    hi_sel = NPH'($urandom);
    lo_sel = NPH'($urandom);
    cli = (phase == 0) ? 1'b0 : (($urandom % 5) == 0);
    clim = ($urandom % 3) == 0;
    moe_set = ($urandom % 6) == 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ctrl_rd", int'(ctrl_rd), 0);
    chk("R1", "moe", int'(moe), 0);
    chk("R1", "step_iv", int'(step_iv), 0);
    chk("R1", "gates", int'({hi_gate, lo_gate}), 0);
    rst_n = 1;
    // R9: set the enable with no trip pending
    moe_set = 1; hi_sel = '1; lo_sel = '1; pwm_in = 1;
    @(posedge clk); model_edge();
    @(negedge clk); cyc++; compare_all();
    moe_set = 0;
    // R3 R4: write preload fields, no C event yet
    wr_en = 1; wr_data = 8'hFF;
    @(posedge clk); model_edge();
    @(negedge clk); cyc++; compare_all();
    chk("R3", "zc_rising before C", int'(zc_rising), 0);
    chk("R2", "bit7 after 0xFF", int'(ctrl_rd), 8'h7F);
    wr_en = 0; direct_mode = 1; phase_wr = 1;
    @(posedge clk); model_edge();
    @(negedge clk); cyc++; compare_all();
    chk("R3", "zc_rising after direct C", int'(zc_rising), 1);
    direct_mode = 0; phase_wr = 0;
    for (int i = 0; i < 6000; i++) begin
      drive_random(i < 1500 ? 0 : 1);
      @(posedge clk); model_edge();
      @(negedge clk); cyc++; compare_all();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule